// File: doc/BRIEF.md
# Divider Programming Loader

This block keeps the programming state of a clock synthesizer: a 9-bit feedback divider value, a 2-bit output divider code and a 2-bit selector for a test pin. The state can be written in two ways. In parallel mode, dedicated pins feed the divider values while an active-low strobe is low, and the values are frozen when that strobe rises. In serial mode, with the parallel strobe high, a three-wire port (shift clock, shift data, load strobe) fills a 14-bit frame. The load strobe then moves the frame into the active registers, or lets it through on every shift while the strobe stays high.

All strobes, the shift clock, the shift data and the parallel pins are brought into one system clock domain by a synchronizer chain, and edges are found there. The active divider values go out to divider logic. A flag reports whether the feedback value lies in the lock range. The test pin shows one of four sources picked by the test selector: constant low, the shift data, the feedback divider output or the synthesized clock. Those two clocks come in as plain inputs.

Top module: `divcfg_loader`

## Requirements
- R1: After reset the test selector is 00, and the divider outputs take the parallel pin values within 8 system clocks of reset release while the parallel strobe is low.
- R2: While the synchronized parallel strobe `par_load_n` is low, `m_val` and `n_val` follow `par_m` and `par_n`, one register stage after the synchronizer.
- R3: After `par_load_n` rises, changes on `par_m` and `par_n` have no effect on `m_val` and `n_val`.
- R4: With `par_load_n` high and `ser_load` low, each rising edge of `ser_clk` shifts `ser_data` into the frame register, and `m_val`, `n_val` and the test selector do not change.
- R5: Frame order, first bit shifted to last: T1, T0, one null bit, N1, N0, M8 down to M0 (14 bits). The value of the null bit has no effect.
- R6: A rising edge of `ser_load` in serial mode copies the frame into M, N and T. After `ser_load` falls, further shifts leave the outputs unchanged.
- R7: While `ser_load` is high in serial mode, every rising edge of `ser_clk` updates M, N and T to the frame contents after that shift.
- R8: In serial mode `test_out` is low for selector 00, follows `ser_data` for 01, follows `mdiv_clk_in` for 10 and follows `fout_clk_in` for 11 (selector = {T1,T0}).
- R9: `test_out` is low whenever `par_load_n` is low.
- R10: `m_in_range` is high exactly when 10 <= `m_val` <= 28.
- R11: Bringing `par_load_n` low after a serial load gives control back to the parallel pins. The test selector keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel load strobe, active low |
| par_m | input | 9 | Parallel feedback divider pins |
| par_n | input | 2 | Parallel output divider pins |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial shift data |
| ser_load | input | 1 | Serial load strobe |
| mdiv_clk_in | input | 1 | Feedback divider output, shown on test pin |
| fout_clk_in | input | 1 | Synthesized output clock, shown on test pin |
| m_val | output | 9 | Active feedback divider value |
| n_val | output | 2 | Active output divider code |
| test_out | output | 1 | Test pin |
| m_in_range | output | 1 | High when m_val lies within 10..28 |

## Verification
The bound checker checks on every cycle that the pins pass through in parallel mode, that the test pin is low in that mode, that the outputs hold when the serial strobe is low, and that a serial transfer or a transparent shift places the frame's low 11 bits on the outputs. Some behaviours only the bench scenarios can show, because each needs a whole sequence of pin activity. These are the bit order of a complete 14-bit frame, that the null bit has no effect, the four test selector codes seen at the pin, and that the values stay frozen once either strobe has closed.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int NULL_W  = 1;
  localparam int NM_W    = N_W + M_W;
  localparam int FRAME_W = T_W + NULL_W + NM_W;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_SDAT = 2'b01,
    TSEL_MDIV = 2'b10,
    TSEL_FOUT = 2'b11
  } tsel_e;

  typedef struct packed {
    tsel_e            tsel;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
  } dcl_cfg_t;
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d[b]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign q[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dcl_shift.sv
module dcl_shift
  import dcl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_mode,
  input  logic            sck_s,
  input  logic            sdat_s,
  output logic            sck_rise,
  output logic [T_W-1:0]  t_now,
  output logic [NM_W-1:0] nm_now,
  output logic [T_W-1:0]  t_nx,
  output logic [NM_W-1:0] nm_nx
);
  logic               sck_q;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;
  logic               shift_en;

  always_comb begin
    sck_rise = sck_s & ~sck_q;
    shift_en = ser_mode & sck_rise;
    frame_d  = shift_en ? {frame_q[FRAME_W-2:0], sdat_s} : frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      sck_q   <= sck_s;
      frame_q <= frame_d;
    end
  end

  assign t_now  = frame_q[FRAME_W-1 -: T_W];
  assign nm_now = frame_q[NM_W-1:0];
  assign t_nx   = frame_q[FRAME_W-2 -: T_W];
  assign nm_nx  = {frame_q[NM_W-2:0], sdat_s};
endmodule

// File: rtl/dcl_cfg_reg.sv
module dcl_cfg_reg
  import dcl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            par_mode,
  input  logic            sload_s,
  input  logic            sck_rise,
  input  logic [M_W-1:0]  pin_m,
  input  logic [N_W-1:0]  pin_n,
  input  logic [T_W-1:0]  t_now,
  input  logic [NM_W-1:0] nm_now,
  input  logic [T_W-1:0]  t_nx,
  input  logic [NM_W-1:0] nm_nx,
  output dcl_cfg_t        cfg
);
  dcl_cfg_t cfg_q;
  dcl_cfg_t cfg_d;
  logic     sload_q;
  logic     sload_rise;
  logic     take_nx;
  logic     take_now;

  always_comb begin
    sload_rise = sload_s & ~sload_q;
    take_nx    = ~par_mode & sload_s & sck_rise;
    take_now   = ~par_mode & sload_rise & ~sck_rise;
    cfg_d      = cfg_q;
    if (par_mode) begin
      cfg_d.m = pin_m;
      cfg_d.n = pin_n;
    end else if (take_nx) begin
      cfg_d.tsel = tsel_e'(t_nx);
      cfg_d.n    = nm_nx[NM_W-1:M_W];
      cfg_d.m    = nm_nx[M_W-1:0];
    end else if (take_now) begin
      cfg_d.tsel = tsel_e'(t_now);
      cfg_d.n    = nm_now[NM_W-1:M_W];
      cfg_d.m    = nm_now[M_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{tsel: TSEL_LOW, n: '0, m: '0};
      sload_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      sload_q <= sload_s;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/dcl_test_mux.sv
module dcl_test_mux
  import dcl_pkg::*;
(
  input  logic  par_mode,
  input  tsel_e tsel,
  input  logic  sdat_s,
  input  logic  mdiv_clk,
  input  logic  fout_clk,
  output logic  test_pin
);
  always_comb begin
    test_pin = 1'b0;
    if (!par_mode) begin
      unique case (tsel)
        TSEL_LOW:  test_pin = 1'b0;
        TSEL_SDAT: test_pin = sdat_s;
        TSEL_MDIV: test_pin = mdiv_clk;
        TSEL_FOUT: test_pin = fout_clk;
        default:   test_pin = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import dcl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_LO        = 10,
  parameter int M_HI        = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           mdiv_clk_in,
  input  logic           fout_clk_in,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic           test_out,
  output logic           m_in_range
);
  localparam int SYNC_W = M_W + N_W + 4;
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[RST_STAGES-1];

  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] sync_bus;
  logic [M_W-1:0]    pin_m_s;
  logic [N_W-1:0]    pin_n_s;
  logic              pload_n_s;
  logic              sload_s;
  logic              sck_s;
  logic              sdat_s;
  logic              par_mode;

  assign raw_bus = {par_m, par_n, par_load_n, ser_load, ser_clk, ser_data};

  dcl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .d    (raw_bus),
    .q    (sync_bus)
  );

  assign {pin_m_s, pin_n_s, pload_n_s, sload_s, sck_s, sdat_s} = sync_bus;
  assign par_mode = ~pload_n_s;

  logic            sck_rise;
  logic [T_W-1:0]  t_now;
  logic [NM_W-1:0] nm_now;
  logic [T_W-1:0]  t_nx;
  logic [NM_W-1:0] nm_nx;

  dcl_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ser_mode(~par_mode),
    .sck_s   (sck_s),
    .sdat_s  (sdat_s),
    .sck_rise(sck_rise),
    .t_now   (t_now),
    .nm_now  (nm_now),
    .t_nx    (t_nx),
    .nm_nx   (nm_nx)
  );

  dcl_cfg_t cfg;

  dcl_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .par_mode(par_mode),
    .sload_s (sload_s),
    .sck_rise(sck_rise),
    .pin_m   (pin_m_s),
    .pin_n   (pin_n_s),
    .t_now   (t_now),
    .nm_now  (nm_now),
    .t_nx    (t_nx),
    .nm_nx   (nm_nx),
    .cfg     (cfg)
  );

  dcl_test_mux u_tmux (
    .par_mode(par_mode),
    .tsel    (cfg.tsel),
    .sdat_s  (sdat_s),
    .mdiv_clk(mdiv_clk_in),
    .fout_clk(fout_clk_in),
    .test_pin(test_out)
  );

  assign m_val = cfg.m;
  assign n_val = cfg.n;

  always_comb begin
    m_in_range = (int'(cfg.m) >= M_LO) && (int'(cfg.m) <= M_HI);
  end
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk
  import dcl_pkg::*;
(
  input logic            clk,
  input logic            rst_i_n,
  input logic            par_mode,
  input logic            sload_s,
  input logic            sck_rise,
  input logic [M_W-1:0]  pin_m_s,
  input logic [NM_W-1:0] nm_now,
  input logic [M_W-1:0]  m_val,
  input logic [N_W-1:0]  n_val,
  input logic            test_out
);
  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    par_mode |=> (m_val == $past(pin_m_s)));

  assert_test_low_par_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    par_mode |-> !test_out);

  assert_hold_closed_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!par_mode && !sload_s) |=> $stable({m_val, n_val}));

  assert_transfer_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!par_mode && $rose(sload_s) && !sck_rise) |=> ({n_val, m_val} == $past(nm_now)));

  assert_transparent_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!par_mode && sload_s && sck_rise) |=> ({n_val, m_val} == nm_now));
endmodule

bind divcfg_loader divcfg_loader_chk u_chk (
  .clk     (clk),
  .rst_i_n (rst_i_n),
  .par_mode(par_mode),
  .sload_s (sload_s),
  .sck_rise(sck_rise),
  .pin_m_s (pin_m_s),
  .nm_now  (nm_now),
  .m_val   (m_val),
  .n_val   (n_val),
  .test_out(test_out)
);

// File: tb/divcfg_loader_tb.sv
module divcfg_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_n;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic       ser_clk, ser_data, ser_load;
  logic       mdiv_clk_in, fout_clk_in;
  logic [8:0] m_val;
  logic [1:0] n_val;
  logic       test_out, m_in_range;

  int checks = 0;
  int fails  = 0;
  logic [13:0] mdl;
  logic [1:0]  exp_t;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  divcfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .mdiv_clk_in(mdiv_clk_in), .fout_clk_in(fout_clk_in),
    .m_val(m_val), .n_val(n_val), .test_out(test_out), .m_in_range(m_in_range)
  );

  function automatic logic rng(input logic [8:0] m);
    return (m >= 9'd10) && (m <= 9'd28);
  endfunction

  function automatic logic exp_test(input logic [1:0] t, input logic pmode,
                                    input logic sd, input logic mc, input logic fc);
    if (pmode) return 1'b0;
    case (t)
      2'b00: return 1'b0;
      2'b01: return sd;
      2'b10: return mc;
      default: return fc;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b; ser_clk = 1'b0; cyc(5);
    ser_clk = 1'b1; cyc(5);
    mdl = {mdl[12:0], b};
    ser_clk = 1'b0;
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
    cyc(5);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; cyc(6);
    ser_load = 1'b0; cyc(6);
    exp_t = mdl[13:12];
  endtask

  task automatic par_load(input logic [8:0] m, input logic [1:0] n);
    par_load_n = 1'b0; par_m = m; par_n = n; cyc(6);
    par_load_n = 1'b1; cyc(6);
  endtask

  task automatic check_mux(input string req);
    for (int k = 0; k < 4; k++) begin
      ser_data = k[0]; mdiv_clk_in = k[1]; fout_clk_in = ~k[0]; cyc(5);
      chk(req, {15'd0, test_out}, {15'd0, exp_test(exp_t, ~par_load_n, ser_data, mdiv_clk_in, fout_clk_in)});
    end
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [13:0] f;
    logic [8:0]  mm;
    logic [1:0]  nn;
    void'($urandom(32'd1234));
    rst_n = 1'b0; par_load_n = 1'b0; par_m = 9'd17; par_n = 2'd2;
    ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    mdiv_clk_in = 1'b1; fout_clk_in = 1'b1; mdl = '0; exp_t = 2'b00;
    cyc(3);
    rst_n = 1'b1; cyc(8);
    // R1 reset defaults come from pins, selector 00
    chk("R1 m", {7'd0, m_val}, 16'd17);
    chk("R1 n", {14'd0, n_val}, 16'd2);
    chk("R9 par low test", {15'd0, test_out}, 16'd0);
    par_load_n = 1'b1; cyc(6);
    chk("R1 tsel 00", {15'd0, test_out}, 16'd0);
    // R2 transparency
    par_load_n = 1'b0; par_m = 9'd10; par_n = 2'd1; cyc(6);
    chk("R2 m", {7'd0, m_val}, 16'd10);
    chk("R10 m=10", {15'd0, m_in_range}, 16'd1);
    par_m = 9'd9; cyc(6);
    chk("R2 m change", {7'd0, m_val}, 16'd9);
    chk("R10 m=9", {15'd0, m_in_range}, 16'd0);
    par_m = 9'd28; cyc(6);
    chk("R10 m=28", {15'd0, m_in_range}, 16'd1);
    par_m = 9'd29; cyc(6);
    chk("R10 m=29", {15'd0, m_in_range}, 16'd0);
    // R3 latch
    par_m = 9'd21; par_n = 2'd3; cyc(6);
    par_load_n = 1'b1; cyc(6);
    par_m = 9'd300; par_n = 2'd0; cyc(6);
    chk("R3 m held", {7'd0, m_val}, 16'd21);
    chk("R3 n held", {14'd0, n_val}, 16'd3);
    // R4/R5/R6 full frame, null=1
    f = {2'b10, 1'b1, 2'b01, 9'd25};
    shift_frame(f);
    chk("R4 m unchanged while shifting", {7'd0, m_val}, 16'd21);
    pulse_load();
    chk("R5 m frame", {7'd0, m_val}, 16'd25);
    chk("R5 n frame", {14'd0, n_val}, 16'd1);
    check_mux("R8 sel10");
    // R5 same frame, null=0
    f = {2'b01, 1'b0, 2'b01, 9'd25};
    shift_frame(f);
    pulse_load();
    chk("R5 null ignored m", {7'd0, m_val}, 16'd25);
    check_mux("R8 sel01");
    // R6 shifts after fall do not alter
    shift_frame({2'b11, 1'b0, 2'b10, 9'd100});
    chk("R6 held after fall", {7'd0, m_val}, 16'd25);
    pulse_load();
    check_mux("R8 sel11");
    chk("R6 load m", {7'd0, m_val}, 16'd100);
    shift_frame({2'b00, 1'b1, 2'b00, 9'd12});
    pulse_load();
    check_mux("R8 sel00");
    // R7 transparent with load high
    ser_load = 1'b1; cyc(6);
    for (int i = 0; i < 6; i++) begin
      shift_bit(i[0] ^ i[1]);
      cyc(2);
      chk("R7 transparent m", {7'd0, m_val}, {7'd0, mdl[8:0]});
      chk("R7 transparent n", {14'd0, n_val}, {14'd0, mdl[10:9]});
    end
    ser_load = 1'b0; cyc(6);
    exp_t = mdl[13:12];
    // R11 parallel regains control
    par_load_n = 1'b0; par_m = 9'd14; par_n = 2'd0; cyc(6);
    chk("R11 m", {7'd0, m_val}, 16'd14);
    chk("R9 par mode test low", {15'd0, test_out}, 16'd0);
    par_load_n = 1'b1; cyc(6);
    check_mux("R11 tsel kept");
    // random mix
    for (int it = 0; it < 30; it++) begin
      mm = 9'($urandom_range(0, 40));
      nn = 2'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        par_load(mm, nn);
      end else begin
        f = {2'($urandom), 1'($urandom), nn, mm};
        shift_frame(f);
        pulse_load();
      end
      chk("R5 random m", {7'd0, m_val}, {7'd0, mm});
      chk("R5 random n", {14'd0, n_val}, {14'd0, nn});
      chk("R10 random range", {15'd0, m_in_range}, {15'd0, rng(mm)});
      ser_data = 1'($urandom); mdiv_clk_in = 1'($urandom); fout_clk_in = 1'($urandom); cyc(5);
      chk("R8 random test", {15'd0, test_out},
          {15'd0, exp_test(exp_t, 1'b0, ser_data, mdiv_clk_in, fout_clk_in)});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule